// File: doc/BRIEF.md
# Converter Host Bus Port with End-of-Conversion Flag

This block is the host side of a successive-approximation converter. A processor reaches it through three active-low strobes: a select, a read and a write. With select asserted, the write strobe starts a conversion and the read strobe fetches the result. The strobes arrive asynchronously, so the block synchronises them before it decodes them. A start holds the search engine in its cleared state for as long as the strobes stay asserted. When the strobes are released, the block sends the engine a one-cycle go pulse. The search engine itself is outside this block. It reports a finished search with a done pulse and an 8-bit code. The block copies that code into a result register. Instead of tri-state pins, the result leaves on a data bus that is qualified by an active-high output enable.

An active-low end-of-conversion flag reports finished searches. Two paths drive it and they compete. A done pulse sets the flag, and the set condition lasts a fixed number of clocks. During that window the set wins over a read. So if the host holds select and read low all the time, it still sees a low pulse of that length. A start request clears the flag and wins over everything else.

A mode input feeds the flag back internally as a start request. This gives free-running operation: each end of conversion immediately starts the next one, and the flag shows only a one-clock strobe. After reset, even in that mode, conversions begin only after an external write.

Top module: `adc_host_port`

## Requirements
- R1: During and after reset `eoc_irq_n`=1, `rdata_oe`=0, `rdata`=0, `search_go`=0 and `search_hold`=0.
- R2: Read or write strobes with `bus_sel_n` high have no effect: `search_hold`, `search_go` and `rdata_oe` stay 0, and `eoc_irq_n` keeps its value.
- R3: With `bus_sel_n` and `bus_wr_n` both low, `search_hold` is 1 from the second clock edge after the strobes fall. `search_go` is 1 for exactly one cycle, after the third edge following the release of the strobes.
- R4: A start request drives `eoc_irq_n` high by the third clock edge after the strobes fall.
- R5: A `search_done` pulse captures `search_code` and drives `eoc_irq_n` low after the next clock edge.
- R6: With `bus_sel_n` and `bus_rd_n` both low, `rdata_oe` is 1 from the second edge and `rdata` shows the captured code. `rdata` is 0 while `rdata_oe` is 0. Once the set window has expired, the read drives `eoc_irq_n` high by the third edge.
- R7: While a read is held continuously, each end of conversion drives `eoc_irq_n` low for exactly SET_HOLD (8) cycles, after which it returns high.
- R8: With `self_loop`=1, a low `eoc_irq_n` lasts exactly one cycle. That same edge raises `search_go`, so conversions repeat with no host action.
- R9: After reset with `self_loop`=1, no `search_go` appears until an external write with select has been issued.
- R10: A `search_done` that arrives while a start request is active is ignored: the code is not captured and `eoc_irq_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel_n | input | 1 | Asynchronous select strobe, active low |
| bus_rd_n | input | 1 | Asynchronous read strobe, active low |
| bus_wr_n | input | 1 | Asynchronous write (start) strobe, active low |
| self_loop | input | 1 | 1 = end of conversion restarts the search internally |
| search_done | input | 1 | One-cycle pulse from the search engine: result ready |
| search_code | input | DATA_W | Result word from the search engine |
| search_hold | output | 1 | Keeps the search engine cleared while a start request is active |
| search_go | output | 1 | One-cycle pulse that launches a search |
| rdata | output | DATA_W | Result bus, zero when not enabled |
| rdata_oe | output | 1 | Result bus enable, active high |
| eoc_irq_n | output | 1 | End-of-conversion flag, active low |

## Verification
The bench uses the default parameters: two synchroniser stages, an 8-bit code and an 8-cycle set window. With these values every latency from a strobe to an output is a short, fixed count of edges that can be predicted. The set window is short enough to measure its full width edge by edge while a read is held. The scoreboard compares every fetched word with the code the bench's own engine model last delivered. The free-running phase checks the width of each flag strobe and the number of go pulses over repeated cycles.

// File: rtl/adc_host_pkg.sv
// Shared types for the converter host port.
// Assumes: strobes are grouped in the order select, read, write.
package adc_host_pkg;
    localparam int STROBE_N = 3;

    // Decoded, active-high view of the synchronised strobes
    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
    } bus_cmd_t;
endpackage

// File: rtl/ahp_sync.sv
// Multi-stage synchroniser for a group of asynchronous strobes.
// Assumes: each bit is an independent level; reset value is given per bit.
module ahp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first stage samples the raw strobes
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ahp_eoc_flag.sv
// End-of-conversion flag with prioritised clear, timed set and read clear.
// Assumes: clr has top priority; a done pulse opens a SET_HOLD-cycle set
// window during which a read cannot clear the flag.
module ahp_eoc_flag #(
    parameter int SET_HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic done,
    input  logic rd_clr,
    output logic flag
);
    localparam int CW = $clog2(SET_HOLD + 1);

    logic [CW-1:0] hold_cnt;

    // flag state: clear beats set, set window beats read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag     <= 1'b0;
            hold_cnt <= '0;
        end else if (clr) begin
            flag     <= 1'b0;
            hold_cnt <= '0;
        end else if (done) begin
            flag     <= 1'b1;
            hold_cnt <= CW'(SET_HOLD - 1);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - CW'(1);
        end else if (rd_clr) begin
            flag     <= 1'b0;
        end
    end
endmodule

// File: rtl/ahp_result_reg.sv
// Result register with an enable-gated output bus.
// Assumes: take is a single-cycle capture strobe.
module ahp_result_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] code,
    input  logic              oe,
    output logic [DATA_W-1:0] bus
);
    logic [DATA_W-1:0] held;

    // capture a finished code
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (take) held <= code;
    end

    // drive zeros when the bus is not enabled
    always_comb bus = oe ? held : '0;
endmodule

// File: rtl/adc_host_port.sv
// Host bus port of a converter: strobe decode, start control, result
// register and end-of-conversion flag with optional self-restart.
// Assumes: search engine pulses search_done for one cycle per result and
// stays cleared while search_hold is high.
module adc_host_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SET_HOLD    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              self_loop,
    input  logic              search_done,
    input  logic [DATA_W-1:0] search_code,
    output logic              search_hold,
    output logic              search_go,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              eoc_irq_n
);
    import adc_host_pkg::*;

    logic [STROBE_N-1:0] strobes_s;
    bus_cmd_t            cmd;
    logic                start_req, read_req, loop_start, clr, flag, req_q;

    ahp_sync #(.W(STROBE_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({bus_sel_n, bus_rd_n, bus_wr_n}),
        .q   (strobes_s)
    );

    // decode synchronised strobes into active-high requests
    always_comb begin
        cmd        = bus_cmd_t'(~strobes_s);
        start_req  = cmd.sel & cmd.wr;
        read_req   = cmd.sel & cmd.rd;
        loop_start = self_loop & flag;
        clr        = start_req | loop_start;
    end

    ahp_eoc_flag #(.SET_HOLD(SET_HOLD)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .done   (search_done),
        .rd_clr (read_req),
        .flag   (flag)
    );

    ahp_result_reg #(.DATA_W(DATA_W)) u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (search_done & ~clr),
        .code  (search_code),
        .oe    (read_req),
        .bus   (rdata)
    );

    // launch pulse on release of a bus start or on a self-restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            search_go <= 1'b0;
        end else begin
            req_q     <= start_req;
            search_go <= (req_q & ~start_req) | loop_start;
        end
    end

    assign search_hold = start_req;
    assign rdata_oe    = read_req;
    assign eoc_irq_n   = ~flag;
endmodule

// File: rtl/adc_host_port_chk.sv
// Property checker for the converter host port, bound to every instance.
// Assumes: observes top-level ports only.
module adc_host_port_chk (
    input logic clk,
    input logic rst_n,
    input logic self_loop,
    input logic search_done,
    input logic search_hold,
    input logic search_go,
    input logic rdata_oe,
    input logic eoc_irq_n
);
    // R4
    start_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        search_hold |=> eoc_irq_n);

    // R5
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (search_done && !search_hold && !(self_loop && !eoc_irq_n)) |=> !eoc_irq_n);

    // R7
    set_window_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(eoc_irq_n) && !self_loop && !search_hold) |=> !eoc_irq_n);

    // R8
    loop_strobe_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (self_loop && !eoc_irq_n) |=> (eoc_irq_n && search_go));

    // R6
    read_keeps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && eoc_irq_n && !search_done) |=> eoc_irq_n);
endmodule

bind adc_host_port adc_host_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .self_loop   (self_loop),
    .search_done (search_done),
    .search_hold (search_hold),
    .search_go   (search_go),
    .rdata_oe    (rdata_oe),
    .eoc_irq_n   (eoc_irq_n)
);

// File: tb/tb_adc_host_port.sv
// Scoreboard bench for the converter host port.
module tb_adc_host_port;
    localparam int DW  = 8;
    localparam int LAT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, self_loop = 1'b0;
    logic man_done = 1'b0, eng_done = 1'b0, engine_on = 1'b0;
    logic [DW-1:0] man_code = '0, eng_code = 8'h10;
    logic search_done, search_hold, search_go, rdata_oe, eoc_irq_n;
    logic [DW-1:0] search_code, rdata;

    int total = 0, bad = 0, go_cnt = 0, eng_cnt = 0;
    logic [DW-1:0] exp_q [$];
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    assign search_done = man_done | eng_done;
    assign search_code = engine_on ? eng_code : man_code;

    adc_host_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .self_loop(self_loop), .search_done(search_done),
        .search_code(search_code), .search_hold(search_hold), .search_go(search_go),
        .rdata(rdata), .rdata_oe(rdata_oe), .eoc_irq_n(eoc_irq_n)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_done(input logic [DW-1:0] c);
        man_code = c;
        man_done = 1'b1;
        ticks(1);
        man_done = 1'b0;
    endtask

    // monitor: go counter, scoreboard pop on each rising output enable
    always @(negedge clk) begin
        if (search_go) go_cnt++;
        if (rdata_oe && !oe_prev) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read", rdata, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rdata == e, "R6 read data", rdata, e);
            end
        end
        oe_prev <= rdata_oe;
    end

    // search engine model: answers each go with a done after LAT cycles
    always @(negedge clk) begin
        eng_done <= 1'b0;
        if (engine_on && search_go) eng_cnt <= LAT;
        else if (eng_cnt > 0) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) begin
                eng_done <= 1'b1;
                eng_code <= eng_code + 8'h01;
            end
        end
    end

    // driver: a full read cycle that pushes the expected word
    task automatic host_read(input logic [DW-1:0] e);
        exp_q.push_back(e);
        bus_sel_n = 1'b0; bus_rd_n = 1'b0;
        ticks(3);
        bus_sel_n = 1'b1; bus_rd_n = 1'b1;
        ticks(2);
    endtask

    initial begin
        ticks(3);
        // R1 reset state
        chk(eoc_irq_n && !rdata_oe && rdata == 0 && !search_go && !search_hold,
            "R1 reset outputs", {eoc_irq_n, rdata_oe, search_go, search_hold}, 4'b1000);
        rst_n = 1'b1;
        ticks(2);
        chk(eoc_irq_n == 1'b1, "R1 flag after reset", eoc_irq_n, 1);

        // R2 write strobe without select
        bus_wr_n = 1'b0;
        ticks(4);
        chk(!search_hold, "R2 write without select", search_hold, 0);
        bus_wr_n = 1'b1;
        ticks(4);
        chk(go_cnt == 0, "R2 no go without select", go_cnt, 0);

        // R3 start request and go pulse timing
        bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        ticks(1);
        chk(!search_hold, "R3 hold not before second edge", search_hold, 0);
        ticks(1);
        chk(search_hold, "R3 hold asserted", search_hold, 1);
        ticks(2);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
        ticks(2);
        chk(!search_go, "R3 go not early", search_go, 0);
        ticks(1);
        chk(search_go, "R3 go pulse", search_go, 1);
        ticks(1);
        chk(!search_go && go_cnt == 1, "R3 go single cycle", go_cnt, 1);

        // R5 end of conversion
        pulse_done(8'hA5);
        chk(!eoc_irq_n && !rdata_oe && rdata == 0, "R5 flag low", eoc_irq_n, 0);

        // R2 read strobe without select
        bus_rd_n = 1'b0;
        ticks(4);
        chk(!rdata_oe && !eoc_irq_n, "R2 read without select", {rdata_oe, eoc_irq_n}, 0);
        bus_rd_n = 1'b1;
        ticks(1);

        // R6 read fetches data and clears flag
        exp_q.push_back(8'hA5);
        bus_sel_n = 1'b0; bus_rd_n = 1'b0;
        ticks(2);
        chk(rdata_oe, "R6 enable after two edges", rdata_oe, 1);
        ticks(1);
        chk(eoc_irq_n, "R6 read clears flag", eoc_irq_n, 1);
        bus_sel_n = 1'b1; bus_rd_n = 1'b1;
        ticks(2);
        chk(!rdata_oe && rdata == 0, "R6 bus off", rdata, 0);

        // R10 done during start request ignored
        bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        ticks(3);
        pulse_done(8'h77);
        chk(eoc_irq_n, "R10 flag stays high", eoc_irq_n, 1);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
        ticks(4);
        host_read(8'hA5);

        // R4 start clears a set flag
        pulse_done(8'h3C);
        ticks(10);
        chk(!eoc_irq_n, "R4 flag set before start", eoc_irq_n, 0);
        bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        ticks(3);
        chk(eoc_irq_n, "R4 start clears flag", eoc_irq_n, 1);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
        ticks(4);
        host_read(8'h3C);

        // R7 held read: low pulse of SET_HOLD cycles
        exp_q.push_back(8'h3C);
        bus_sel_n = 1'b0; bus_rd_n = 1'b0;
        ticks(4);
        pulse_done(8'hC3);
        begin
            int w = 0;
            while (!eoc_irq_n && w < 20) begin
                w++;
                @(negedge clk);
            end
            chk(w == 8, "R7 held-read pulse width", w, 8);
        end
        chk(rdata == 8'hC3, "R7 held-read data", rdata, 8'hC3);
        bus_sel_n = 1'b1; bus_rd_n = 1'b1;
        ticks(3);
        host_read(8'hC3);

        // R9 self-loop after reset waits for a write
        rst_n = 1'b0; self_loop = 1'b1; engine_on = 1'b1;
        ticks(2);
        rst_n = 1'b1;
        go_cnt = 0;
        ticks(60);
        chk(go_cnt == 0 && eoc_irq_n, "R9 no start before write", go_cnt, 0);

        // R8 free-running strobes
        bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        ticks(3);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
        begin
            int lows = 0, w = 0, wrong = 0;
            for (int i = 0; i < 150; i++) begin
                @(negedge clk);
                if (!eoc_irq_n) w++;
                else if (w != 0) begin
                    lows++;
                    if (w != 1) wrong++;
                    w = 0;
                end
            end
            chk(wrong == 0, "R8 strobe width one cycle", wrong, 0);
            chk(lows >= 3, "R8 repeated conversions", lows, 3);
            chk(go_cnt >= 4, "R8 go pulses", go_cnt, 4);
        end
        engine_on = 1'b0; self_loop = 1'b0;
        ticks(10);

        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule